// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of the slave side of a three-wire serial EEPROM. A host selects the device with `cs` and clocks commands in on `di`, one bit per rising edge of `sclk`. Each command has four parts:

- A start bit of 1.
- A two-bit opcode.
- An address, most significant bit first.
- For a write, a data word.

The storage is an internal register array. It is organised either as 16-bit words or as 8-bit bytes. The `org` input selects the organisation, unless a parameter fixes it.

A write-protect latch guards programming. It powers up closed, opens only on an enable command, and closes again on a disable command or on reset. Reads ignore the latch. A read answers on `sdo` with a zero lead bit and then the addressed word. While `cs` stays high, the read keeps streaming the following words and wraps at the end of the array.

Reset stands for power-up. It clears the framing logic and the latch, but not the stored contents.

Top module: `uwire_prom`

## Requirements
- R1: After reset the write-protect latch is closed, `sdo_oe` is low and the stored contents are unchanged. A write sent before any enable command is ignored.
- R2: `di` is sampled on rising `sclk` while `cs` is high. Zeros before the start bit are skipped. The frame is a start bit of 1, opcode bits MSB first, then address bits MSB first. The address is 6 bits when `org` is 1 and 7 bits when `org` is 0.
- R3: Opcode 00 with address top bits 11 opens the latch. The latch stays open across any number of later commands.
- R4: Opcode 00 with address top bits 00 closes the latch. Writes after it are ignored.
- R5: Opcode 01 is followed by the address and a data word, MSB first: 16 bits when `org` is 1, 8 bits when `org` is 0. The word is stored on the last data bit, and only if the latch is open.
- R6: Opcode 10 is a read. `sdo_oe` stays low until the rising edge that samples the last address bit. On that edge `sdo_oe` goes high and `sdo` shows 0. Each following rising edge puts out one data bit, MSB first.
- R7: A read returns stored data whether the latch is open or closed.
- R8: If `cs` stays high after a word's last bit, the next rising edge puts out the MSB of the word at the next address, with no lead zero. The address wraps from the last location to 0.
- R9: In byte organisation, byte address 2k+1 is bits 15:8 of word k and byte address 2k is bits 7:0 of word k.
- R10: While `cs` is low, `sdo_oe` is low. A rising edge with `cs` low aborts the command in progress, so a write cut short stores nothing.
- R11: The following commands leave both the latch and the stored data unchanged:
  - opcode 11;
  - opcode 00 with address top bits 01;
  - opcode 00 with address top bits 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sclk | input | 1 | Serial clock; rising edge samples `di` and updates `sdo` |
| cs | input | 1 | Chip select, active high; low ends any command |
| di | input | 1 | Serial command, address and data input |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The bench builds the block with its default parameters:

- 16-bit words and a 6-bit word address, which gives 64 words or 128 bytes.
- The organisation taken from the `org` pin.

Because the organisation follows the pin, one run exercises both layouts. The bench writes data in byte form and reads it back in word form, which checks the byte-lane mapping.

The array is small enough to fill completely. Sequential reads can therefore cross the wrap point, from location 63 to 0 in word form and from 127 to 0 in byte form, with every word holding a known value.

// File: rtl/uwp_pkg.sv
package uwp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_WDAT,
      ST_READ,
      ST_DONE
   } uwp_state_e;

   localparam logic [1:0] OP_MISC  = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] MISC_LOCK   = 2'b00;
   localparam logic [1:0] MISC_UNLOCK = 2'b11;

   localparam int ORG_PIN    = 0;
   localparam int ORG_WIDE   = 1;
   localparam int ORG_NARROW = 2;

endpackage

// File: rtl/uwp_frame.sv
module uwp_frame
   import uwp_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              di,
   input  logic              wide,
   output logic              rd_go,
   output logic              wr_go,
   output logic [ADDR_W:0]   cmd_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              wen,
   output logic              in_read
);

   localparam int AW_MAX = ADDR_W + 1;
   localparam int HALF   = WORD_W / 2;
   localparam int CMAX   = (WORD_W > AW_MAX) ? WORD_W : AW_MAX;
   localparam int CNT_W  = $clog2(CMAX + 1);

   uwp_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        opc;
   logic [AW_MAX-1:0] adr_q;
   logic [WORD_W-1:0] dat_q;
   logic              wen_q;

   logic [CNT_W-1:0]  aw_n;
   logic [CNT_W-1:0]  dw_n;
   logic [AW_MAX-1:0] adr_full;
   logic [WORD_W-1:0] dat_full;
   logic [1:0]        top2;
   logic              adr_last;
   logic              dat_last;
   logic              misc_hit;
   logic              ewen_hit;
   logic              ewds_hit;

   always_comb begin
      aw_n     = wide ? CNT_W'(ADDR_W) : CNT_W'(AW_MAX);
      dw_n     = wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
      adr_full = {adr_q[AW_MAX-2:0], di};
      dat_full = {dat_q[WORD_W-2:0], di};
      top2     = wide ? adr_full[ADDR_W-1 -: 2] : adr_full[AW_MAX-1 -: 2];
      adr_last = (st == ST_ADR) && (cnt == aw_n - CNT_W'(1));
      dat_last = (st == ST_WDAT) && (cnt == dw_n - CNT_W'(1));
      misc_hit = cs && adr_last && (opc == OP_MISC);
      ewen_hit = misc_hit && (top2 == MISC_UNLOCK);
      ewds_hit = misc_hit && (top2 == MISC_LOCK);
   end

   assign rd_go    = cs && adr_last && (opc == OP_READ);
   assign wr_go    = cs && dat_last && wen_q;
   assign cmd_addr = (st == ST_WDAT) ? adr_q : adr_full;
   assign wr_data  = dat_full;
   assign wen      = wen_q;
   assign in_read  = (st == ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         opc   <= '0;
         adr_q <= '0;
         dat_q <= '0;
         wen_q <= 1'b0;
      end else begin
         if (ewen_hit) begin
            wen_q <= 1'b1;
         end else if (ewds_hit) begin
            wen_q <= 1'b0;
         end
         if (!cs) begin
            st  <= ST_IDLE;
            cnt <= '0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (di) begin
                     st    <= ST_OPC;
                     cnt   <= '0;
                     adr_q <= '0;
                     dat_q <= '0;
                  end
               end
               ST_OPC: begin
                  opc <= {opc[0], di};
                  if (cnt == CNT_W'(1)) begin
                     st  <= ST_ADR;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_ADR: begin
                  adr_q <= adr_full;
                  if (adr_last) begin
                     cnt <= '0;
                     case (opc)
                        OP_READ:  st <= ST_READ;
                        OP_WRITE: st <= ST_WDAT;
                        default:  st <= ST_DONE;
                     endcase
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_WDAT: begin
                  dat_q <= dat_full;
                  if (dat_last) begin
                     st <= ST_DONE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_WEN_OPEN_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen_q) |-> $past(ewen_hit)); // R3

   AST_WEN_CLOSE_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wen_q) |-> $past(ewds_hit)); // R4

endmodule

// File: rtl/uwp_store.sv
module uwp_store #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              wide,
   input  logic [ADDR_W:0]   rd_addr,
   output logic [WORD_W-1:0] rd_word,
   input  logic              we,
   input  logic [ADDR_W:0]   wr_addr,
   input  logic [WORD_W-1:0] wr_data
);

   localparam int AW_MAX = ADDR_W + 1;
   localparam int HALF   = WORD_W / 2;
   localparam int WORDS  = 1 << ADDR_W;

   logic [WORD_W-1:0] bank [WORDS];
   logic [ADDR_W-1:0] widx;
   logic [ADDR_W-1:0] ridx;
   logic [WORD_W-1:0] rsel;

   assign widx = wide ? wr_addr[ADDR_W-1:0] : wr_addr[AW_MAX-1:1];
   assign ridx = wide ? rd_addr[ADDR_W-1:0] : rd_addr[AW_MAX-1:1];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (we && (widx == ADDR_W'(g))) begin
            if (wide) begin
               q <= wr_data;
            end else if (wr_addr[0]) begin
               q[WORD_W-1:HALF] <= wr_data[HALF-1:0];
            end else begin
               q[HALF-1:0] <= wr_data[HALF-1:0];
            end
         end
      end
      assign bank[g] = q;
   end

   always_comb begin
      rsel = bank[ridx];
      if (wide) begin
         rd_word = rsel;
      end else if (rd_addr[0]) begin
         rd_word = {rsel[WORD_W-1:HALF], {HALF{1'b0}}};
      end else begin
         rd_word = {rsel[HALF-1:0], {HALF{1'b0}}};
      end
   end

endmodule

// File: rtl/uwp_rdshift.sv
module uwp_rdshift #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wide,
   input  logic              load,
   input  logic [ADDR_W:0]   load_addr,
   output logic [ADDR_W:0]   rd_addr,
   input  logic [WORD_W-1:0] rd_word,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int AW_MAX = ADDR_W + 1;
   localparam int HALF   = WORD_W / 2;
   localparam int CNT_W  = $clog2(WORD_W + 1);

   logic [AW_MAX-1:0] ptr;
   logic [WORD_W-1:0] sh;
   logic [CNT_W-1:0]  left;
   logic              dq;
   logic              act;
   logic [AW_MAX-1:0] amask;
   logic [CNT_W-1:0]  dw_n;

   assign amask   = wide ? {1'b0, {ADDR_W{1'b1}}} : {AW_MAX{1'b1}};
   assign dw_n    = wide ? CNT_W'(WORD_W) : CNT_W'(HALF);
   assign rd_addr = load ? load_addr : ptr;
   assign sdo     = dq;
   assign sdo_oe  = cs && act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         sh   <= '0;
         left <= '0;
         dq   <= 1'b0;
         act  <= 1'b0;
      end else if (!cs) begin
         act <= 1'b0;
      end else if (load) begin
         sh   <= rd_word;
         ptr  <= (load_addr + AW_MAX'(1)) & amask;
         dq   <= 1'b0;
         left <= dw_n;
         act  <= 1'b1;
      end else if (act) begin
         if (left == '0) begin
            dq   <= rd_word[WORD_W-1];
            sh   <= rd_word << 1;
            ptr  <= (ptr + AW_MAX'(1)) & amask;
            left <= dw_n - CNT_W'(1);
         end else begin
            dq   <= sh[WORD_W-1];
            sh   <= sh << 1;
            left <= left - CNT_W'(1);
         end
      end
   end

   AST_LEAD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> !dq); // R6

   AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (left <= dw_n)); // R8

endmodule

// File: rtl/uwire_prom.sv
module uwire_prom
   import uwp_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ADDR_W   = 6,
   parameter int ORG_MODE = ORG_PIN
) (
   input  logic rst_n,
   input  logic sclk,
   input  logic cs,
   input  logic di,
   input  logic org,
   output logic sdo,
   output logic sdo_oe
);

   localparam int AW_MAX = ADDR_W + 1;

   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_word
      $error("WORD_W must be even and at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (ORG_MODE < ORG_PIN || ORG_MODE > ORG_NARROW) begin : g_bad_org
      $error("ORG_MODE out of range");
   end

   logic wide;
   if (ORG_MODE == ORG_WIDE) begin : g_org_wide
      assign wide = 1'b1;
   end else if (ORG_MODE == ORG_NARROW) begin : g_org_narrow
      assign wide = 1'b0;
   end else begin : g_org_pin
      assign wide = org;
   end

   logic              rd_go;
   logic              wr_go;
   logic [AW_MAX-1:0] cmd_addr;
   logic [WORD_W-1:0] wr_data;
   logic              wen;
   logic              in_read;
   logic [AW_MAX-1:0] rd_addr;
   logic [WORD_W-1:0] rd_word;

   uwp_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_frame (
      .clk      (sclk),
      .rst_n    (rst_n),
      .cs       (cs),
      .di       (di),
      .wide     (wide),
      .rd_go    (rd_go),
      .wr_go    (wr_go),
      .cmd_addr (cmd_addr),
      .wr_data  (wr_data),
      .wen      (wen),
      .in_read  (in_read)
   );

   uwp_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
      .clk     (sclk),
      .wide    (wide),
      .rd_addr (rd_addr),
      .rd_word (rd_word),
      .we      (wr_go),
      .wr_addr (cmd_addr),
      .wr_data (wr_data)
   );

   uwp_rdshift #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rdshift (
      .clk       (sclk),
      .rst_n     (rst_n),
      .cs        (cs),
      .wide      (wide),
      .load      (rd_go),
      .load_addr (cmd_addr),
      .rd_addr   (rd_addr),
      .rd_word   (rd_word),
      .sdo       (sdo),
      .sdo_oe    (sdo_oe)
   );

   AST_OE_ONLY_READING: assert property (@(posedge sclk) disable iff (!rst_n)
      sdo_oe |-> in_read); // R6

   AST_WRITE_NEEDS_OPEN: assert property (@(posedge sclk) disable iff (!rst_n)
      wr_go |=> $stable(wen)); // R5

endmodule

// File: tb/uwire_prom_bench.sv
module uwire_prom_bench;

   logic rst_n = 1'b0;
   logic sclk  = 1'b0;
   logic cs    = 1'b0;
   logic di    = 1'b0;
   logic org   = 1'b1;
   logic sdo;
   logic sdo_oe;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [15:0] mdl [64];
   bit          mwen = 0;

   always #10 sclk = ~sclk;

   uwire_prom u_uwire_prom (
      .rst_n  (rst_n),
      .sclk   (sclk),
      .cs     (cs),
      .di     (di),
      .org    (org),
      .sdo    (sdo),
      .sdo_oe (sdo_oe)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sb(input logic b);
      @(negedge sclk);
      cs = 1'b1;
      di = b;
   endtask

   task automatic cs_off();
      @(negedge sclk);
      cs = 1'b0;
      di = 1'b0;
      @(negedge sclk);
   endtask

   task automatic send_hdr(input logic [1:0] opc, input logic [6:0] addr);
      int aw = org ? 6 : 7;
      sb(1'b1);
      sb(opc[1]);
      sb(opc[0]);
      for (int i = aw - 1; i >= 0; i--) sb(addr[i]);
   endtask

   function automatic logic [15:0] exp_unit(input logic [6:0] a);
      if (org) return mdl[a[5:0]];
      return a[0] ? {8'h00, mdl[a[6:1]][15:8]} : {8'h00, mdl[a[6:1]][7:0]};
   endfunction

   task automatic send_misc(input logic [1:0] top);
      send_hdr(2'b00, org ? {1'b0, top, 4'b0} : {top, 5'b0});
      cs_off();
      if (top == 2'b11) mwen = 1;
      if (top == 2'b00) mwen = 0;
   endtask

   task automatic do_write(input logic [6:0] addr, input logic [15:0] data);
      int dw = org ? 16 : 8;
      send_hdr(2'b01, addr);
      for (int i = dw - 1; i >= 0; i--) sb(data[i]);
      cs_off();
      if (mwen) begin
         if (org) mdl[addr[5:0]] = data;
         else if (addr[0]) mdl[addr[6:1]][15:8] = data[7:0];
         else mdl[addr[6:1]][7:0] = data[7:0];
      end
   endtask

   task automatic read_check(input logic [6:0] addr, input int n, input int nz, input string tag);
      int dw = org ? 16 : 8;
      logic [6:0] a = addr;
      logic [15:0] w;
      for (int i = 0; i < nz; i++) sb(1'b0);
      send_hdr(2'b10, addr);
      check(sdo_oe == 1'b0, {tag, " R6 idle before last address bit"}, {15'd0, sdo_oe}, 16'd0);
      @(negedge sclk);
      check(sdo_oe && sdo == 1'b0, {tag, " R6 lead zero"}, {14'd0, sdo_oe, sdo}, 16'h0002);
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int b = 0; b < dw; b++) begin
            @(negedge sclk);
            w = {w[14:0], sdo};
         end
         check(w == exp_unit(a), tag, w, exp_unit(a));
         a = org ? {1'b0, a[5:0] + 6'd1} : a + 7'd1;
      end
      cs_off();
   endtask

   task automatic t_reset_state();
      check(sdo_oe == 1'b0, "R1 output off after reset", {15'd0, sdo_oe}, 16'd0);
      for (int i = 0; i < 3; i++) sb(1'b0);
      @(negedge sclk);
      check(sdo_oe == 1'b0, "R1 output off idle cs high", {15'd0, sdo_oe}, 16'd0);
      cs_off();
   endtask

   task automatic t_fill();
      org = 1'b1;
      send_misc(2'b11);
      for (int i = 0; i < 64; i++) do_write(7'(i), 16'(i * 16'h0107) ^ 16'hC35A);
      read_check(7'd0, 4, 0, "R5 fill readback");
      read_check(7'd40, 1, 0, "R5 single word");
   endtask

   task automatic t_persist_reset();
      @(negedge sclk);
      rst_n = 1'b0;
      mwen = 0;
      @(negedge sclk);
      rst_n = 1'b1;
      do_write(7'd5, 16'hDEAD);
      read_check(7'd5, 1, 0, "R1 write before enable ignored");
   endtask

   task automatic t_latch_persist();
      send_misc(2'b11);
      do_write(7'd9, 16'h1357);
      do_write(7'd10, 16'h2468);
      read_check(7'd9, 2, 0, "R3 latch stays open");
   endtask

   task automatic t_lock();
      send_misc(2'b00);
      do_write(7'd9, 16'hFFFF);
      read_check(7'd9, 1, 0, "R4 write after disable ignored");
      read_check(7'd30, 1, 0, "R7 read with latch closed");
   endtask

   task automatic t_seq_wrap();
      read_check(7'd62, 4, 0, "R8 word wrap");
   endtask

   task automatic t_leading_zeros();
      read_check(7'd17, 1, 4, "R2 leading zeros skipped");
   endtask

   task automatic t_byte_mode();
      org = 1'b1;
      send_misc(2'b11);
      org = 1'b0;
      read_check(7'd7, 1, 0, "R9 odd byte is upper half");
      read_check(7'd6, 1, 0, "R9 even byte is lower half");
      do_write(7'd4, 16'h009C);
      org = 1'b1;
      read_check(7'd2, 1, 0, "R9 byte write lands in lower half");
      org = 1'b0;
      read_check(7'd126, 3, 0, "R8 byte wrap");
      read_check(7'd33, 2, 0, "R2 seven bit address");
      org = 1'b1;
      send_misc(2'b00);
   endtask

   task automatic t_abort();
      send_misc(2'b11);
      send_hdr(2'b01, 7'd11);
      for (int i = 0; i < 8; i++) sb(1'b1);
      cs_off();
      read_check(7'd11, 1, 0, "R10 aborted write stores nothing");
      send_hdr(2'b10, 7'd11);
      for (int i = 0; i < 4; i++) @(negedge sclk);
      cs = 1'b0;
      #1;
      check(sdo_oe == 1'b0, "R10 output off when cs low", {15'd0, sdo_oe}, 16'd0);
      @(negedge sclk);
      @(negedge sclk);
      check(sdo_oe == 1'b0, "R10 output stays off", {15'd0, sdo_oe}, 16'd0);
      send_misc(2'b00);
   endtask

   task automatic t_ignored();
      send_misc(2'b11);
      send_misc(2'b10);
      send_misc(2'b01);
      send_hdr(2'b11, 7'd0);
      cs_off();
      read_check(7'd0, 1, 0, "R11 opcode 11 leaves data");
      do_write(7'd12, 16'hABCD);
      read_check(7'd12, 1, 0, "R11 latch still open");
      send_misc(2'b00);
      send_misc(2'b01);
      send_misc(2'b10);
      do_write(7'd12, 16'h0F0F);
      read_check(7'd12, 1, 0, "R11 latch still closed");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge sclk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge sclk);
      rst_n = 1'b1;
      @(negedge sclk);
      t_reset_state();
      t_fill();
      t_persist_reset();
      t_latch_persist();
      t_lock();
      t_seq_wrap();
      t_leading_zeros();
      t_byte_mode();
      t_abort();
      t_ignored();
      finish_run();
   end

endmodule